// File: doc/BRIEF.md
# Audio Buffer DRAM Access Sequencer

This block turns single-word memory requests from an audio compression engine into strobe sequences for one or two 4-bit-wide page-mode DRAMs. A request carries a direction, a word address and four bits of write data. The sequencer splits the address into a row and a column for the selected memory layout, and drives the multiplexed address bus, the row and column strobes, the write strobe and the data-bus enable. Every timing is a fixed number of system clocks. A read returns its data together with a one-clock done pulse.

When two devices are fitted, the top bit of the word address picks the device. Only that device's column strobe moves. Accesses refresh the array in normal use, so there is no periodic refresh. A burst of row-only refresh cycles runs when the memory system is switched on, and again when the encoder enable is newly raised while the system is on. Requests are accepted one at a time, and `ready` is low while a cycle or a burst is in progress.

Top module: `abuf_dram_seq`

## Requirements
- R1: After reset, `ras_n`, `cas0_n`, `cas1_n` and `we_n` are high, `dq_oe` and `done` are low, and `ready` is high.
- R2: An access is 8 phases long, numbered 0 to 7 from the clock after acceptance. `ras_n` is low in phases 1 to 5, which is 5 clocks, and high for at least 3 clocks between falls.
- R3: The selected column strobe is low in phases 3 to 5. It therefore falls 2 clocks after `ras_n` falls, stays low 3 clocks and stays high for at least 5.
- R4: `ma` carries the row in phases 0 and 1 and the column in phases 2 to 7. This gives 1 clock of setup and 1 of hold around the row strobe, and 1 clock of setup and 5 of hold around the column strobe.
- R5: In a write, `we_n` is low and `dq_oe` is high in phases 0 to 5, so both start 3 clocks before the column strobe falls and last 6 clocks. `dq_out` carries the request's write data for that whole window.
- R6: In a read, `we_n` stays high and `dq_oe` stays low. `rdata` takes the value of `dq_in` from phase 5, the last clock before the column strobe rises. `done` is high for phase 7 only.
- R7: `cfg` selects the layout: 00 is two 16M devices, 01 is two 4M devices, 10 is one 4M device, 11 is one 16M device. For 16M, the row is address bits [21:11] and the column is bits [10:0]. For 4M, the row is bits [19:10] and the column is bits [9:0], with `ma[10]` held at 0.
- R8: In the dual layouts, address bit 22 (16M) or bit 20 (4M) selects the device. Bit value 0 fires `cas0_n` and 1 fires `cas1_n`. The other strobe stays high for the whole cycle. In the single layouts only `cas0_n` is used. The two strobes are never low together.
- R9: A rising `sys_on`, or a rising `enc_en` while `sys_on` is high, starts a burst of 15 row-only cycles. In these cycles both column strobes and `we_n` stay high. A rising `enc_en` while `sys_on` is low starts no burst.
- R10: `ready` is low from the clock after acceptance until the cycle ends, and throughout a refresh burst. A request is taken only on a clock edge where `req` and `ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 2 | Memory layout select |
| sys_on | input | 1 | Memory system on level |
| enc_en | input | 1 | Encoder enable level |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Request can be accepted |
| done | output | 1 | Access completes this clock |
| rdata | output | 4 | Read data |
| ras_n | output | 1 | Row strobe |
| cas0_n | output | 1 | Column strobe, device 0 |
| cas1_n | output | 1 | Column strobe, device 1 |
| we_n | output | 1 | Write strobe |
| ma | output | 11 | Multiplexed row/column address |
| dq_out | output | 4 | Data bus out |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 4 | Data bus in |

## Verification
The hardest condition to reach is read data taken from exactly the right phase. A bus value that stays steady would hide a sampling point that is off by one clock. The stimulus therefore changes `dq_in` every phase of every read, to a seed XORed with the phase number. The only value that can be correct is the seed XORed with 5. The refresh trigger is hard to reach for a related reason: it depends on the history of two enables. The stimulus raises `sys_on`, then raises `enc_en` with the system on, and then raises `enc_en` again with the system off. Each time it counts row-strobe falls until `ready` returns.

// File: rtl/abuf_dram_seq.sv
module abuf_dram_seq #(
  parameter int RA_W       = 11,
  parameter int DQ_W       = 4,
  parameter int REF_CYCLES = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg,
  input  logic                sys_on,
  input  logic                enc_en,
  input  logic                req,
  input  logic                req_wr,
  input  logic [2*RA_W:0]     req_addr,
  input  logic [DQ_W-1:0]     req_wdata,
  output logic                ready,
  output logic                done,
  output logic [DQ_W-1:0]     rdata,
  output logic                ras_n,
  output logic                cas0_n,
  output logic                cas1_n,
  output logic                we_n,
  output logic [RA_W-1:0]     ma,
  output logic [DQ_W-1:0]     dq_out,
  output logic                dq_oe,
  input  logic [DQ_W-1:0]     dq_in
);
  localparam int WA_W = 2*RA_W + 1;
  localparam int RN_W = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_ACC = 2'd1, S_REF = 2'd2;

  logic [1:0]      mode;
  logic [2:0]      ph;
  logic [WA_W-1:0] addr_q;
  logic            wr_q, sel_q, rf_pend, on_q, en_q;
  logic [DQ_W-1:0] wd_q;
  logic [RN_W-1:0] rf_n;
  logic [RA_W-1:0] rf_row;

  wire big  = cfg[1] ~^ cfg[0];
  wire dual = ~cfg[1];
  wire trig = sys_on & (~on_q | (enc_en & ~en_q));
  wire sel_in = dual & (big ? req_addr[2*RA_W] : req_addr[2*RA_W-2]);

  wire [RA_W-1:0] row = big ? addr_q[2*RA_W-1:RA_W] : {1'b0, addr_q[2*RA_W-3:RA_W-1]};
  wire [RA_W-1:0] col = big ? addr_q[RA_W-1:0]      : {1'b0, addr_q[RA_W-2:0]};
  wire [RA_W-1:0] rrow = big ? rf_row : {1'b0, rf_row[RA_W-2:0]};

  wire acc     = (mode == S_ACC);
  wire ras_on  = (mode != S_IDLE) && (ph >= 3'd1) && (ph <= 3'd5);
  wire cas_on  = acc && (ph >= 3'd3) && (ph <= 3'd5);
  wire wr_win  = acc && wr_q && (ph <= 3'd5);

  assign ready  = (mode == S_IDLE) && !rf_pend;
  assign done   = acc && (ph == 3'd7);
  assign ras_n  = ~ras_on;
  assign cas0_n = ~(cas_on & ~sel_q);
  assign cas1_n = ~(cas_on & sel_q);
  assign we_n   = ~wr_win;
  assign dq_oe  = wr_win;
  assign dq_out = wd_q;
  assign ma     = (mode == S_REF) ? rrow : (ph <= 3'd1) ? row : col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= S_IDLE; ph <= '0; addr_q <= '0; wr_q <= 1'b0; sel_q <= 1'b0;
      wd_q <= '0; rdata <= '0; rf_pend <= 1'b0; rf_n <= '0; rf_row <= '0;
      on_q <= 1'b0; en_q <= 1'b0;
    end else begin
      on_q <= sys_on;
      en_q <= enc_en;
      case (mode)
        S_IDLE: begin
          ph <= '0;
          if (rf_pend) begin
            mode    <= S_REF;
            rf_pend <= 1'b0;
          end else if (req) begin
            mode   <= S_ACC;
            addr_q <= req_addr;
            wr_q   <= req_wr;
            wd_q   <= req_wdata;
            sel_q  <= sel_in;
          end
        end
        S_ACC: begin
          ph <= ph + 3'd1;
          if (ph == 3'd5) rdata <= dq_in;
          if (ph == 3'd7) mode <= S_IDLE;
        end
        default: begin
          ph <= ph + 3'd1;
          if (ph == 3'd7) begin
            rf_row <= rf_row + 1'b1;
            if (rf_n == RN_W'(REF_CYCLES-1)) begin
              rf_n <= '0;
              mode <= S_IDLE;
            end else begin
              rf_n <= rf_n + 1'b1;
            end
          end
        end
      endcase
      if (trig) rf_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/abuf_dram_seq_chk.sv
module abuf_dram_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas0_n,
  input logic cas1_n,
  input logic we_n,
  input logic ready,
  input logic done
);
  assert_ras_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ($past(ras_n,5) == 1'b0 && $past(ras_n,6) == 1'b1));
  assert_ras_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(ras_n,1) && $past(ras_n,2) && $past(ras_n,3)));
  assert_cas_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas0_n && cas1_n) |-> ($past(ras_n,2) == 1'b0 && $past(ras_n,3) == 1'b1));
  assert_one_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cas0_n && !cas1_n));
  assert_we_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas0_n && cas1_n) && !we_n) |-> ($past(we_n,3) == 1'b0 && $past(we_n,4) == 1'b1));
  assert_busy_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !ready);
  assert_done_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cas0_n && cas1_n,1) && !$past(cas0_n && cas1_n,2)));
endmodule

bind abuf_dram_seq abuf_dram_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas0_n(cas0_n), .cas1_n(cas1_n),
  .we_n(we_n), .ready(ready), .done(done)
);

// File: tb/abuf_dram_seq_tb.sv
module abuf_dram_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg = 2'b11;
  logic sys_on = 1'b0, enc_en = 1'b0, req = 1'b0, req_wr = 1'b0;
  logic [22:0] req_addr = '0;
  logic [3:0] req_wdata = '0, dq_in = '0;
  logic ready, done, ras_n, cas0_n, cas1_n, we_n, dq_oe;
  logic [3:0] rdata, dq_out;
  logic [10:0] ma;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  abuf_dram_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .sys_on(sys_on), .enc_en(enc_en),
    .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .done(done), .rdata(rdata), .ras_n(ras_n), .cas0_n(cas0_n),
    .cas1_n(cas1_n), .we_n(we_n), .ma(ma), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(input logic [1:0] c, input logic [22:0] a, input logic wr, input logic [3:0] wd, input logic [3:0] seed);
    int rb, row, col, sel, exp_we, caslow;
    rb  = (c[1] == c[0]) ? 11 : 10;
    row = int'(a >> rb) & ((1 << rb) - 1);
    col = int'(a) & ((1 << rb) - 1);
    sel = (!c[1]) ? (int'(a >> (2*rb)) & 1) : 0;
    @(negedge clk);
    chk("R10 ready idle", ready, 1);
    cfg = c; req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      req = 1'b0;
      dq_in = seed ^ 4'(k);
      caslow = (k >= 3 && k <= 5) ? 1 : 0;
      exp_we = (wr && k <= 5) ? 0 : 1;
      chk("R2 ras_n", ras_n, (k >= 1 && k <= 5) ? 0 : 1);
      chk("R3/R8 cas0_n", cas0_n, (caslow && sel == 0) ? 0 : 1);
      chk("R3/R8 cas1_n", cas1_n, (caslow && sel == 1) ? 0 : 1);
      chk("R4/R7 ma", ma, (k <= 1) ? row : col);
      chk(wr ? "R5 we_n" : "R6 we_n", we_n, exp_we);
      chk(wr ? "R5 dq_oe" : "R6 dq_oe", dq_oe, 1 - exp_we);
      if (wr && k <= 5) chk("R5 dq_out", dq_out, wd);
      chk("R6 done", done, (k == 7) ? 1 : 0);
      chk("R10 ready busy", ready, 0);
      if (!wr && k >= 6) chk("R6 rdata", rdata, seed ^ 4'd5);
    end
  endtask

  task automatic burst(input string tag, input int exp);
    int cnt = 0;
    logic prev = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!ras_n && prev) cnt++;
      prev = ras_n;
      if (!cas0_n || !cas1_n || !we_n) chk({tag, " strobes"}, 0, 1);
      if (i > 2 && ready) break;
    end
    chk(tag, cnt, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [22:0] addrs [4];
    addrs[0] = 23'h000000; addrs[1] = 23'h7FFFFF; addrs[2] = 23'h2A5C3B; addrs[3] = 23'h500801;
    repeat (3) @(negedge clk);
    chk("R1 ras_n", ras_n, 1); chk("R1 cas", cas0_n & cas1_n, 1);
    chk("R1 we_n", we_n, 1); chk("R1 dq_oe", dq_oe, 0);
    chk("R1 done", done, 0); chk("R1 ready", ready, 1);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 4; j++)
        for (int w = 0; w < 2; w++)
          access(2'(c), addrs[j] ^ 23'(j*c*4097), w[0], 4'(c*4 + j + w), 4'(j*3 + c + 1));
    // R8: dual 4M with bit 20 set only
    access(2'b01, 23'h100000, 1'b0, 4'h0, 4'h9);
    access(2'b00, 23'h400000, 1'b1, 4'hA, 4'h3);
    // R9: refresh bursts
    @(negedge clk); sys_on = 1'b1;
    burst("R9 burst on sys_on", 15);
    @(negedge clk); enc_en = 1'b1;
    burst("R9 burst on enc_en", 15);
    @(negedge clk); sys_on = 1'b0; enc_en = 1'b0;
    repeat (2) @(negedge clk); enc_en = 1'b1;
    burst("R9 no burst when off", 0);
    access(2'b11, 23'h1234AB, 1'b0, 4'h0, 4'h6);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule